// File: doc/BRIEF.md
# Serial Receiver with Level-Driven Request-to-Send

This block is the receive half of an asynchronous serial port. A deserialiser oversamples the line with a sixteen-times baud enable, qualifies each start bit at its midpoint and gathers eight data bits, least significant first. Each completed character goes into a sixteen-entry first-in first-out store. Software, or a neighbouring block, drains the store through a read strobe. The oldest character is always visible on the data output.

The block throttles the far-end transmitter by itself through an active-low request-to-send output. A two-bit select picks the throttle point. For the three lower settings, the output is released once the stored count reaches the threshold. For the highest setting, the output is held until the store is nearly full, and the decision then depends on whether a character is currently arriving. A character that completes while the store is full is dropped, and a sticky overrun output is set.

Top module: `uart_rx_autorts`

## Requirements
- R1: While `rx_en` is low, `rts_n` is high and the line is ignored, so no character is stored. When `rx_en` is high and the store is empty, `rts_n` is low.
- R2: A character is one low start bit, eight data bits sent least significant first, and one stop bit, each lasting 16 `baud_tick` pulses. A low level that has ended by the eighth tick after it was first seen is rejected, and nothing is stored.
- R3: The store holds up to 16 characters and returns them in arrival order. `rd_data` shows the oldest character, `rd_stb` removes it, and `rx_empty` is high exactly when nothing is stored.
- R4: `rx_trig` encodes the throttle setting: 0 = 1 character, 1 = 4, 2 = 8, 3 = 14.
- R5: For settings 0, 1 and 2, `rts_n` goes high one clock after the stored count is at or above the threshold, and goes low one clock after the count falls below it.
- R6: For settings 0, 1 and 2, a character that arrives after `rts_n` has gone high is still stored while space remains.
- R7: For setting 3, when 15 characters are stored, `rts_n` goes high once the first data bit of the next incoming character has been sampled.
- R8: For setting 3, `rts_n` is low when two or more slots are free, even while a character is arriving. It is also low when exactly one slot is free and no character is past its first data bit. It is high when the store is full.
- R9: For setting 3, the first read from a full store brings `rts_n` low again when no character is arriving.
- R10: A character that completes while the store is full is discarded, and `overrun` goes high and stays high until reset.
- R11: A read strobe while `rx_empty` is high has no effect: the store stays empty, and later characters are returned intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_en | input | 1 | Receiver enable |
| serial_in | input | 1 | Asynchronous serial line, idle high |
| baud_tick | input | 1 | One-clock pulse at sixteen times the bit rate |
| rx_trig | input | 2 | Throttle setting select |
| rd_stb | input | 1 | Remove the oldest stored character |
| rd_data | output | 8 | Oldest stored character |
| rx_empty | output | 1 | Store holds nothing |
| rts_n | output | 1 | Active-low request-to-send |
| overrun | output | 1 | Sticky flag for a dropped character |

## Verification
The bound checker watches the stored count against the depth on every cycle. It also checks the one-clock mapping from count, setting, enable and the mid-character flag to `rts_n`, the stickiness of overrun and its setting on a full store, and that a read of an empty store leaves the count unchanged. What only the bench scenarios can show is the serial framing itself: midpoint start qualification, glitch rejection, bit order, arrival order through the store, the extra character accepted after throttling, and the exact point inside the sixteenth character where the line is held off.

// File: rtl/rxf_pkg.sv
// Shared constants, types and helpers for the serial receiver with
// level-driven request-to-send. Assumes a power-of-two store depth.
package rxf_pkg;

    localparam int DATA_W     = 8;
    localparam int OVS        = 16;
    localparam int FIFO_DEPTH = 16;
    localparam int LVL_W      = $clog2(FIFO_DEPTH + 1);

    typedef enum logic [1:0] {
        TRIG_1  = 2'd0,
        TRIG_4  = 2'd1,
        TRIG_8  = 2'd2,
        TRIG_14 = 2'd3
    } trig_e;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP
    } rx_state_e;

    // Map a throttle select code to its character count.
    function automatic logic [LVL_W-1:0] trig_count(input logic [1:0] sel);
        case (sel)
            TRIG_1:  return LVL_W'(1);
            TRIG_4:  return LVL_W'(4);
            TRIG_8:  return LVL_W'(8);
            default: return LVL_W'(14);
        endcase
    endfunction

endpackage

// File: rtl/rx_deser.sv
// Oversampling serial deserialiser.
// Synchronises the line, qualifies a start bit at half a bit time, and
// samples each data bit and the stop bit at its centre. It emits a
// one-clock valid pulse with the assembled character, and it flags when a
// character is past its first data bit. Assumes baud_tick is a one-clock
// pulse at OVS times the bit rate. The stop bit value is not checked.
module rx_deser #(
    parameter int DATA_W = rxf_pkg::DATA_W,
    parameter int OVS    = rxf_pkg::OVS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              baud_tick,
    input  logic              serial_in,
    output logic              byte_valid,
    output logic [DATA_W-1:0] byte_data,
    output logic              in_flight
);
    import rxf_pkg::*;

    localparam int CNT_W = $clog2(OVS);
    localparam int BIT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] HALF_M1 = CNT_W'(OVS / 2 - 1);
    localparam logic [CNT_W-1:0] FULL_M1 = CNT_W'(OVS - 1);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

    logic [1:0]        sync_q;
    logic              line;
    rx_state_e         state_q;
    logic [CNT_W-1:0]  tick_q;
    logic [BIT_W-1:0]  bit_q;
    logic [DATA_W-1:0] shift_q;
    logic              valid_q;

    assign line = sync_q[1];

    // Two-stage synchroniser for the asynchronous line, idle high.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= 2'b11;
        else        sync_q <= {sync_q[0], serial_in};
    end

    // Frame state machine, advanced on baud ticks only.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            state_q <= RX_IDLE;
            tick_q  <= '0;
            bit_q   <= '0;
            shift_q <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            if (baud_tick) begin
                case (state_q)
                    RX_IDLE: begin
                        if (!line) begin
                            state_q <= RX_START;
                            tick_q  <= '0;
                        end
                    end
                    RX_START: begin
                        if (tick_q == HALF_M1) begin
                            tick_q <= '0;
                            bit_q  <= '0;
                            state_q <= line ? RX_IDLE : RX_DATA;
                        end else begin
                            tick_q <= tick_q + 1'b1;
                        end
                    end
                    RX_DATA: begin
                        if (tick_q == FULL_M1) begin
                            tick_q  <= '0;
                            shift_q <= {line, shift_q[DATA_W-1:1]};
                            if (bit_q == LAST_BIT) state_q <= RX_STOP;
                            else                   bit_q   <= bit_q + 1'b1;
                        end else begin
                            tick_q <= tick_q + 1'b1;
                        end
                    end
                    default: begin
                        if (tick_q == FULL_M1) begin
                            tick_q  <= '0;
                            valid_q <= 1'b1;
                            state_q <= RX_IDLE;
                        end else begin
                            tick_q <= tick_q + 1'b1;
                        end
                    end
                endcase
            end
        end
    end

    assign byte_valid = valid_q;
    assign byte_data  = shift_q;
    assign in_flight  = ((state_q == RX_DATA) && (bit_q != '0)) || (state_q == RX_STOP);

endmodule

// File: rtl/rx_fifo.sv
// Character store with show-ahead read.
// Accepts a push unless it is full, in which case the character is dropped
// and a sticky overrun flag is set. A pop while empty is ignored. Assumes
// DEPTH is a power of two.
module rx_fifo #(
    parameter int DATA_W = rxf_pkg::DATA_W,
    parameter int DEPTH  = rxf_pkg::FIFO_DEPTH
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [DATA_W-1:0]          push_data,
    input  logic                       pop,
    output logic [DATA_W-1:0]          rd_data,
    output logic [$clog2(DEPTH+1)-1:0] level,
    output logic                       empty,
    output logic                       overrun
);
    localparam int AW = $clog2(DEPTH);
    localparam int LW = $clog2(DEPTH + 1);
    localparam logic [LW-1:0] FULL_LVL = LW'(DEPTH);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wr_q;
    logic [AW-1:0]     rd_q;
    logic [LW-1:0]     lvl_q;
    logic              ovr_q;
    logic              full;
    logic              do_push;
    logic              do_pop;

    assign full    = (lvl_q == FULL_LVL);
    assign empty   = (lvl_q == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;

    // Storage array write; contents need no reset.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_q] <= push_data;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            lvl_q <= '0;
        end else begin
            if (do_push) wr_q <= wr_q + 1'b1;
            if (do_pop)  rd_q <= rd_q + 1'b1;
            case ({do_push, do_pop})
                2'b10:   lvl_q <= lvl_q + 1'b1;
                2'b01:   lvl_q <= lvl_q - 1'b1;
                default: lvl_q <= lvl_q;
            endcase
        end
    end

    // Sticky record of a character dropped on a full store.
    always_ff @(posedge clk) begin
        if (!rst_n)              ovr_q <= 1'b0;
        else if (push && full)   ovr_q <= 1'b1;
    end

    assign rd_data = mem[rd_q];
    assign level   = lvl_q;
    assign overrun = ovr_q;

endmodule

// File: rtl/rts_ctrl.sv
// Request-to-send decision.
// Low settings hold the sender off at a character threshold. The top
// setting holds it off only from the free space and the arrival state of
// the current character. The output is registered and is high while the
// receiver is disabled or in reset.
module rts_ctrl #(
    parameter int DEPTH = rxf_pkg::FIFO_DEPTH
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       enable,
    input  logic [1:0]                 trig_sel,
    input  logic [$clog2(DEPTH+1)-1:0] level,
    input  logic                       in_flight,
    output logic                       rts_n
);
    import rxf_pkg::*;

    localparam int LW = $clog2(DEPTH + 1);

    logic [LW-1:0] free_slots;
    logic [LW-1:0] threshold;
    logic          hold_off;
    logic          rts_q;

    assign free_slots = LW'(DEPTH) - level;
    assign threshold  = LW'(trig_count(trig_sel));

    // Choose the hold-off rule for the selected setting.
    always_comb begin
        if (trig_sel == TRIG_14) begin
            hold_off = !(((free_slots >= LW'(1)) && !in_flight) || (free_slots > LW'(1)));
        end else begin
            hold_off = (level >= threshold);
        end
    end

    // Register the active-low output.
    always_ff @(posedge clk) begin
        if (!rst_n) rts_q <= 1'b1;
        else        rts_q <= !enable || hold_off;
    end

    assign rts_n = rts_q;

endmodule

// File: rtl/uart_rx_autorts.sv
// Top of the serial receiver with level-driven request-to-send.
// Connects the deserialiser, the character store and the request-to-send
// decision. Assumes rx_trig and rx_en are driven synchronously to clk.
module uart_rx_autorts #(
    parameter int DATA_W     = rxf_pkg::DATA_W,
    parameter int OVS        = rxf_pkg::OVS,
    parameter int FIFO_DEPTH = rxf_pkg::FIFO_DEPTH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              serial_in,
    input  logic              baud_tick,
    input  logic [1:0]        rx_trig,
    input  logic              rd_stb,
    output logic [DATA_W-1:0] rd_data,
    output logic              rx_empty,
    output logic              rts_n,
    output logic              overrun
);
    localparam int LVL_W = $clog2(FIFO_DEPTH + 1);

    logic              byte_valid;
    logic [DATA_W-1:0] byte_data;
    logic              in_flight;
    logic [LVL_W-1:0]  fifo_level;

    rx_deser #(.DATA_W(DATA_W), .OVS(OVS)) u_deser (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (rx_en),
        .baud_tick  (baud_tick),
        .serial_in  (serial_in),
        .byte_valid (byte_valid),
        .byte_data  (byte_data),
        .in_flight  (in_flight)
    );

    rx_fifo #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (byte_valid),
        .push_data (byte_data),
        .pop       (rd_stb),
        .rd_data   (rd_data),
        .level     (fifo_level),
        .empty     (rx_empty),
        .overrun   (overrun)
    );

    rts_ctrl #(.DEPTH(FIFO_DEPTH)) u_rts (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (rx_en),
        .trig_sel  (rx_trig),
        .level     (fifo_level),
        .in_flight (in_flight),
        .rts_n     (rts_n)
    );

endmodule

// File: rtl/rxf_checker.sv
// Property checker for the receiver, bound into every instance of the top.
// Uses the default store depth from the package.
module rxf_checker #(
    parameter int DEPTH = rxf_pkg::FIFO_DEPTH
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       rx_en,
    input logic [1:0]                 rx_trig,
    input logic                       rd_stb,
    input logic                       rx_empty,
    input logic                       rts_n,
    input logic                       overrun,
    input logic                       byte_valid,
    input logic                       in_flight,
    input logic [$clog2(DEPTH+1)-1:0] level
);
    import rxf_pkg::*;

    localparam int LW = $clog2(DEPTH + 1);
    localparam logic [LW-1:0] FULL_LVL = LW'(DEPTH);

    logic [LW-1:0] thr;
    assign thr = LW'(trig_count(rx_trig));

    assert_level_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        level <= FULL_LVL);

    assert_rts_disabled_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> rts_n);

    assert_thr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en && rx_trig != TRIG_14 && level >= thr) |=> rts_n);

    assert_thr_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en && rx_trig != TRIG_14 && level < thr) |=> !rts_n);

    assert_mid_char_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en && rx_trig == TRIG_14 && level == FULL_LVL - 1'b1 && in_flight) |=> rts_n);

    assert_full_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en && rx_trig == TRIG_14 && level == FULL_LVL) |=> rts_n);

    assert_space_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en && rx_trig == TRIG_14 && level <= FULL_LVL - LW'(2)) |=> !rts_n);

    assert_one_slot_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en && rx_trig == TRIG_14 && level == FULL_LVL - 1'b1 && !in_flight) |=> !rts_n);

    assert_overrun_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && level == FULL_LVL) |=> overrun);

    assert_overrun_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);

    assert_empty_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && rx_empty && !byte_valid) |=> (level == '0));

endmodule

bind uart_rx_autorts rxf_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_en      (rx_en),
    .rx_trig    (rx_trig),
    .rd_stb     (rd_stb),
    .rx_empty   (rx_empty),
    .rts_n      (rts_n),
    .overrun    (overrun),
    .byte_valid (byte_valid),
    .in_flight  (in_flight),
    .level      (fifo_level)
);

// File: tb/tb_uart_rx_autorts.sv
`timescale 1ns/1ps
module tb_uart_rx_autorts;

    localparam int BIT_CLKS = 64;   // 16 ticks of 4 clocks each

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_en = 1'b0;
    logic       serial_in = 1'b1;
    logic       baud_tick = 1'b0;
    logic [1:0] rx_trig = 2'd0;
    logic       rd_stb = 1'b0;
    logic [7:0] rd_data;
    logic       rx_empty;
    logic       rts_n;
    logic       overrun;

    int total = 0;
    int bad = 0;
    logic [7:0] exp_q[$];
    logic [1:0] div_q = 2'd0;

    uart_rx_autorts dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_en     (rx_en),
        .serial_in (serial_in),
        .baud_tick (baud_tick),
        .rx_trig   (rx_trig),
        .rd_stb    (rd_stb),
        .rd_data   (rd_data),
        .rx_empty  (rx_empty),
        .rts_n     (rts_n),
        .overrun   (overrun)
    );

    always #2.5 clk = ~clk;

    // Baud enable: one pulse every four clocks.
    always @(posedge clk) begin
        div_q     <= div_q + 2'd1;
        baud_tick <= (div_q == 2'd3);
    end

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Driver: send one frame; queue it as expected when it should be stored.
    task automatic send_byte(input logic [7:0] d, input bit keep);
        if (keep) exp_q.push_back(d);
        serial_in = 1'b0;
        wait_clk(BIT_CLKS);
        for (int i = 0; i < 8; i++) begin
            serial_in = d[i];
            wait_clk(BIT_CLKS);
        end
        serial_in = 1'b1;
        wait_clk(BIT_CLKS + 8);
    endtask

    // Monitor: pop the oldest expected item and compare with the output.
    task automatic read_byte(input string req);
        logic [7:0] want;
        check({req, " not empty"}, rx_empty, 0);
        if (exp_q.size() == 0) begin
            check({req, " queue"}, 1, 0);
        end else begin
            want = exp_q.pop_front();
            check({req, " data"}, rd_data, want);
        end
        rd_stb = 1'b1;
        wait_clk(1);
        rd_stb = 1'b0;
        wait_clk(2);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(3);
        // R1: reset / disabled state
        check("R1 rts_n disabled", rts_n, 1);
        check("R3 empty after reset", rx_empty, 1);
        check("R10 overrun after reset", overrun, 0);

        rx_en = 1'b1;
        wait_clk(3);
        check("R1 rts_n enabled empty", rts_n, 0);

        // R4/R5 setting 0: threshold 1
        rx_trig = 2'd0;
        send_byte(8'hA5, 1'b1);
        check("R5 trig1 hold", rts_n, 1);
        read_byte("R2 bit order");
        check("R5 trig1 release", rts_n, 0);

        // R2: glitch rejected
        serial_in = 1'b0;
        wait_clk(20);
        serial_in = 1'b1;
        wait_clk(300);
        check("R2 glitch rejected", rx_empty, 1);

        // R4/R5/R6 setting 1: threshold 4, one extra kept
        rx_trig = 2'd1;
        for (int i = 0; i < 3; i++) send_byte(8'h10 + 8'(i), 1'b1);
        check("R5 trig4 below", rts_n, 0);
        send_byte(8'h81, 1'b1);
        check("R5 trig4 hold", rts_n, 1);
        send_byte(8'h7E, 1'b1);
        check("R6 extra stored hold", rts_n, 1);
        read_byte("R6 first");
        check("R5 trig4 still held at 4", rts_n, 1);
        read_byte("R3 order");
        check("R5 trig4 release", rts_n, 0);
        for (int i = 0; i < 3; i++) read_byte("R6 order");
        check("R3 empty drained", rx_empty, 1);

        // R4/R5 setting 2: threshold 8
        rx_trig = 2'd2;
        for (int i = 0; i < 7; i++) send_byte(8'hC0 ^ 8'(i * 37), 1'b1);
        check("R5 trig8 below", rts_n, 0);
        send_byte(8'h33, 1'b1);
        check("R5 trig8 hold", rts_n, 1);
        read_byte("R3 trig8");
        check("R5 trig8 release", rts_n, 0);
        for (int i = 0; i < 7; i++) read_byte("R3 trig8 order");

        // R7/R8/R9/R10 setting 3
        rx_trig = 2'd3;
        for (int i = 0; i < 14; i++) send_byte(8'(i * 17 + 3), 1'b1);
        check("R8 fourteen stored", rts_n, 0);
        fork
            send_byte(8'h99, 1'b1);
            begin
                wait_clk(160);
                check("R8 two free while arriving", rts_n, 0);
            end
        join
        check("R8 one free idle", rts_n, 0);
        fork
            send_byte(8'h5A, 1'b1);
            begin
                wait_clk(32);
                check("R7 before first data bit", rts_n, 0);
                wait_clk(128);
                check("R7 after first data bit", rts_n, 1);
            end
        join
        check("R8 full hold", rts_n, 1);
        check("R10 no overrun yet", overrun, 0);
        send_byte(8'hEE, 1'b0);
        check("R10 overrun set", overrun, 1);
        check("R8 full hold after drop", rts_n, 1);
        read_byte("R9 first of full");
        check("R9 release after read", rts_n, 0);
        for (int i = 0; i < 15; i++) read_byte("R10 survivors");
        check("R3 empty after full drain", rx_empty, 1);
        check("R10 overrun sticky", overrun, 1);

        // R11: read while empty
        rd_stb = 1'b1;
        wait_clk(1);
        rd_stb = 1'b0;
        wait_clk(3);
        check("R11 still empty", rx_empty, 1);
        send_byte(8'h3C, 1'b1);
        read_byte("R11 intact after empty read");
        check("R11 empty again", rx_empty, 1);

        // R1: disabled receiver ignores the line
        rx_en = 1'b0;
        wait_clk(3);
        check("R1 rts_n on disable", rts_n, 1);
        send_byte(8'h42, 1'b0);
        check("R1 nothing stored", rx_empty, 1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule